// File: doc/BRIEF.md
# Strip-Mining Vector Length Sequencer

This block splits a loop of `n` elements, with `n` known only at run time, into a series of vector strips that are each no longer than the maximum vector length (MVL). It gives out one strip at a time, as a length and a starting element offset, to a downstream vector unit over a valid/ready handshake. The arithmetic on the elements is done elsewhere.

The odd-sized piece is handled first. The first strip carries `n mod MVL` elements, and every later strip is a full MVL. When `n` is an exact multiple of MVL, the empty first piece is skipped. A one-cycle done pulse marks the end of each sequence. `n` is captured when the start strobe is accepted. A strobe that arrives while a sequence is in progress has no effect.

Top module: `strip_seq`

## Requirements
- R1: While `valid_o` is high, `len_o` is at least 1 and at most MVL (default 32).
- R2: The first strip of a sequence has offset 0 and length `n mod MVL`. When that remainder is 0, the first strip has length MVL.
- R3: Every strip after the first has length exactly MVL.
- R4: The offset of each strip after the first equals the previous strip's offset plus the previous strip's length.
- R5: A strip is consumed only in a cycle where `valid_o` and `ready_i` are both high. While `valid_o` is high and `ready_i` is low, `len_o`, `off_o` and `last_o` hold their values in the next cycle.
- R6: `last_o` is high exactly with the strip whose offset plus length equals `n`. `done_o` is high for exactly one cycle, the cycle after that strip is consumed, and no strip is presented in that cycle.
- R7: When `n` is 0, `done_o` is high in the cycle after the start strobe is sampled, and no strip is presented.
- R8: `n_i` is sampled only in the cycle in which `start_i` is accepted. `start_i` is accepted only when neither `valid_o` nor `done_o` is high; otherwise it has no effect.
- R9: After reset, `valid_o`, `last_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe for a new sequence |
| n_i | input | N_W (32) | Total element count, unsigned |
| ready_i | input | 1 | Downstream can take a strip |
| len_o | output | LEN_W (6) | Length of the current strip |
| off_o | output | N_W (32) | Starting element offset of the current strip |
| valid_o | output | 1 | A strip is presented |
| last_o | output | 1 | The presented strip is the final one |
| done_o | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
Two events can fall in the same cycle: a start strobe (R8) and the final handshake of a running sequence (R6). The bench provokes this by holding `start_i` high, with a different count on `n_i`, through an entire sequence. The strobe therefore coincides with the last handshake and with the done cycle. The scoreboard then checks that the strips match the first count only, that done pulses once, and that no further strip appears. Random back-pressure on `ready_i` makes stalls land on first strips, middle strips and last strips, and every stall is checked for stable outputs.

// File: rtl/strip_seq_pkg.sv
package strip_seq_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_RUN  = 2'd1,
      SEQ_FIN  = 2'd2
   } seq_state_t;

endpackage

// File: rtl/strip_first_len.sv
module strip_first_len #(
   parameter int MVL   = 32,
   parameter int N_W   = 32,
   parameter int LEN_W = $clog2(MVL + 1)
) (
   input  logic [N_W-1:0]   n_i,
   output logic [LEN_W-1:0] first_len_o,
   output logic             zero_n_o
);
   localparam int REM_W = (MVL > 1) ? $clog2(MVL) : 1;
   localparam bit IS_POW2 = ((MVL & (MVL - 1)) == 0);
   localparam logic [LEN_W-1:0] MVL_L = LEN_W'(MVL);

   logic [REM_W-1:0] rem;

   generate
      if (IS_POW2) begin : g_mask
         assign rem = n_i[REM_W-1:0];
      end else begin : g_mod
         logic [N_W-1:0] rem_full;
         assign rem_full = n_i % N_W'(MVL);
         assign rem      = rem_full[REM_W-1:0];
      end
   endgenerate

   always_comb begin
      if (rem == '0) first_len_o = MVL_L;
      else           first_len_o = LEN_W'(rem);
   end

   assign zero_n_o = (n_i == '0);

endmodule

// File: rtl/strip_cursor.sv
module strip_cursor #(
   parameter int MVL   = 32,
   parameter int N_W   = 32,
   parameter int LEN_W = $clog2(MVL + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             advance_i,
   input  logic [N_W-1:0]   n_i,
   input  logic [LEN_W-1:0] first_len_i,
   output logic [N_W-1:0]   off_o,
   output logic [LEN_W-1:0] len_o,
   output logic             is_last_o
);
   localparam logic [LEN_W-1:0] MVL_L = LEN_W'(MVL);

   logic [N_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_o  <= '0;
         remain <= '0;
         len_o  <= '0;
      end else if (load_i) begin
         off_o  <= '0;
         remain <= n_i;
         len_o  <= first_len_i;
      end else if (advance_i) begin
         off_o  <= off_o + N_W'(len_o);
         remain <= remain - N_W'(len_o);
         len_o  <= MVL_L;
      end
   end

   assign is_last_o = (remain == N_W'(len_o));

   // a consumed strip never exceeds what remains
   p_no_overrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
      advance_i |-> (remain >= N_W'(len_o)));

endmodule

// File: rtl/strip_ctrl.sv
module strip_ctrl
   import strip_seq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic zero_n_i,
   input  logic ready_i,
   input  logic is_last_i,
   output logic load_o,
   output logic advance_o,
   output logic valid_o,
   output logic done_o
);
   seq_state_t st, st_nx;
   logic       fire;

   assign valid_o   = (st == SEQ_RUN);
   assign done_o    = (st == SEQ_FIN);
   assign fire      = valid_o && ready_i;
   assign load_o    = (st == SEQ_IDLE) && start_i;
   assign advance_o = fire && !is_last_i;

   always_comb begin
      st_nx = st;
      unique case (st)
         SEQ_IDLE: if (start_i) st_nx = zero_n_i ? SEQ_FIN : SEQ_RUN;
         SEQ_RUN:  if (fire && is_last_i) st_nx = SEQ_FIN;
         SEQ_FIN:  st_nx = SEQ_IDLE;
         default:  st_nx = SEQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= SEQ_IDLE;
      else        st <= st_nx;
   end

   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !valid_o);

endmodule

// File: rtl/strip_seq.sv
module strip_seq #(
   parameter int MVL   = 32,
   parameter int N_W   = 32,
   parameter int LEN_W = $clog2(MVL + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [N_W-1:0]   n_i,
   input  logic             ready_i,
   output logic [LEN_W-1:0] len_o,
   output logic [N_W-1:0]   off_o,
   output logic             valid_o,
   output logic             last_o,
   output logic             done_o
);
   localparam logic [LEN_W-1:0] MVL_L = LEN_W'(MVL);

   generate
      if (MVL < 2) begin : g_bad_mvl
         $error("strip_seq: MVL must be at least 2");
      end
      if (LEN_W < $clog2(MVL + 1)) begin : g_bad_len
         $error("strip_seq: LEN_W too narrow for MVL");
      end
      if (N_W < LEN_W) begin : g_bad_nw
         $error("strip_seq: N_W must be at least LEN_W");
      end
   endgenerate

   logic [LEN_W-1:0] first_len;
   logic             zero_n;
   logic             load, advance, is_last;

   strip_first_len #(.MVL(MVL), .N_W(N_W), .LEN_W(LEN_W)) i_first (
      .n_i         (n_i),
      .first_len_o (first_len),
      .zero_n_o    (zero_n)
   );

   strip_ctrl i_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .zero_n_i  (zero_n),
      .ready_i   (ready_i),
      .is_last_i (is_last),
      .load_o    (load),
      .advance_o (advance),
      .valid_o   (valid_o),
      .done_o    (done_o)
   );

   strip_cursor #(.MVL(MVL), .N_W(N_W), .LEN_W(LEN_W)) i_cursor (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (load),
      .advance_i   (advance),
      .n_i         (n_i),
      .first_len_i (first_len),
      .off_o       (off_o),
      .len_o       (len_o),
      .is_last_o   (is_last)
   );

   assign last_o = valid_o && is_last;

   p_len_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (len_o != '0 && len_o <= MVL_L));

   p_full_after_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && ready_i && !last_o) |=> (valid_o && len_o == MVL_L));

   p_off_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && ready_i && !last_o) |=>
         (off_o == $past(off_o) + N_W'($past(len_o))));

   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !ready_i) |=>
         (valid_o && $stable(len_o) && $stable(off_o) && $stable(last_o)));

   p_done_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && ready_i && last_o) |=> done_o);

   p_zero_n_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !valid_o && !done_o && n_i == '0) |=> (done_o && !valid_o));

endmodule

// File: tb/test_strip_seq.sv
module test_strip_seq;
   localparam int MVL   = 32;
   localparam int N_W   = 32;
   localparam int LEN_W = $clog2(MVL + 1);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic [N_W-1:0]   n_i = '0;
   logic             ready_i = 1'b0;
   logic [LEN_W-1:0] len_o;
   logic [N_W-1:0]   off_o;
   logic             valid_o, last_o, done_o;

   always #2.5 clk = ~clk;   // 200 MHz

   strip_seq #(.MVL(MVL), .N_W(N_W), .LEN_W(LEN_W)) i_strip_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .n_i(n_i),
      .ready_i(ready_i), .len_o(len_o), .off_o(off_o),
      .valid_o(valid_o), .last_o(last_o), .done_o(done_o)
   );

   int checks = 0;
   int fails  = 0;

   typedef struct packed {
      logic [N_W-1:0]   off;
      logic [LEN_W-1:0] len;
      logic             last;
   } strip_t;

   strip_t exp_q[$];

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // ready pattern: 0 always ready, 1 pseudo-random back-pressure
   int         ready_mode = 0;
   logic [7:0] lfsr = 8'hA5;
   always @(posedge clk) begin
      #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      ready_i = (ready_mode == 0) ? 1'b1 : (lfsr[1:0] != 2'b00);
   end

   // monitor: pops expected strips on each handshake
   logic             prev_stall = 1'b0;
   logic [LEN_W-1:0] prev_len;
   logic [N_W-1:0]   prev_off;
   logic             prev_last;
   always @(negedge clk) begin
      if (rst_n && valid_o) begin
         if (prev_stall) begin
            check(len_o == prev_len && off_o == prev_off && last_o == prev_last,
                  "R5", "stalled strip changed, off", off_o, prev_off);
         end
         if (ready_i) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R8", "unexpected strip at off", off_o, -1);
            end else begin
               strip_t e;
               e = exp_q.pop_front();
               check(len_o == e.len, "R1/R2/R3", "strip length", len_o, e.len);
               check(off_o == e.off, "R4", "strip offset", off_o, e.off);
               check(last_o == e.last, "R6", "last flag", last_o, e.last);
            end
         end
      end
      prev_stall = rst_n && valid_o && !ready_i;
      prev_len   = len_o;
      prev_off   = off_o;
      prev_last  = last_o;
   end

   // driver: pushes expected strips, then launches the sequence
   task automatic run_seq(input logic [N_W-1:0] n, input bit hold_start);
      longint off = 0;
      longint rem = longint'(n) % MVL;
      int     dones = 0;
      int     guard = 0;
      if (rem != 0) begin
         exp_q.push_back('{off: '0, len: LEN_W'(rem), last: (rem == longint'(n))});
         off = rem;
      end
      while (off < longint'(n)) begin
         exp_q.push_back('{off: N_W'(off), len: LEN_W'(MVL),
                           last: (off + MVL == longint'(n))});
         off += MVL;
      end
      @(posedge clk); #1;
      start_i = 1'b1;
      n_i = n;
      @(posedge clk); #1;
      n_i = n + 32'd77;   // different count, must not be taken (R8)
      if (!hold_start) start_i = 1'b0;
      if (n == 0) begin
         @(negedge clk);
         check(done_o == 1'b1, "R7", "done after start with n=0", done_o, 1);
         check(valid_o == 1'b0, "R7", "no strip with n=0", valid_o, 0);
      end else begin
         while (!done_o && guard < 2000) begin
            @(negedge clk);
            guard++;
         end
      end
      check(done_o == 1'b1, "R6", "done reached", done_o, 1);
      check(exp_q.size() == 0, "R6", "strips left at done", exp_q.size(), 0);
      check(valid_o == 1'b0, "R6", "strip during done", valid_o, 0);
      start_i = 1'b0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         if (done_o) dones++;
         check(valid_o == 1'b0, "R8", "strip after sequence", valid_o, 0);
      end
      check(dones == 0, "R6", "extra done pulses", dones, 0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(valid_o == 0 && last_o == 0 && done_o == 0, "R9", "outputs in reset",
            {valid_o, last_o, done_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(valid_o == 0 && done_o == 0, "R9", "idle after reset",
            {valid_o, done_o}, 0);

      ready_mode = 0;
      run_seq(32'd0, 1'b0);     // R7
      run_seq(32'd5, 1'b0);     // single odd strip, R2 R6
      run_seq(32'd32, 1'b0);    // exact MVL, R2
      run_seq(32'd100, 1'b0);   // 4 + 3*32, R2 R3 R4
      run_seq(32'd1, 1'b0);
      run_seq(32'd33, 1'b0);
      ready_mode = 1;
      run_seq(32'd200, 1'b0);   // R5 under back-pressure
      run_seq(32'd128, 1'b0);   // multiple of MVL, R2
      run_seq(32'd31, 1'b0);
      run_seq(32'd97, 1'b1);    // start held through last handshake, R8
      run_seq(32'd0, 1'b1);     // R7 with held start
      ready_mode = 0;
      run_seq(32'd64, 1'b1);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule